// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames (start bit, data bits sent least significant bit first, an optional parity bit, one stop bit). It works from a one-clock-wide strobe, `os_tick`, that pulses sixteen times per bit period. A frame first builds up in a shift register. When the stop bit has been sampled, a fixed rule decides whether the shift register is copied into the visible data register and which sticky status flags are raised.

Four flags are kept: data ready, overrun, framing error and parity error. A frame with a framing or parity error is still copied to the data register, but it does not raise data ready. If data ready is still set when a frame completes, the overrun flag is raised instead and the data register keeps its old contents. The receiver keeps running through a line break, so a framing flag that is cleared during a break comes back on the next frame. Software clears data ready with a read strobe and clears each error flag with its own clear input.

The receive enable input stops the receiver but leaves every flag and the data register unchanged. The serial input passes through a synchronizer of `SYNC_STAGES` flops before the framer sees it.

Top module: `uart_os_rx`

## Requirements
- R1: On an `os_tick` where the synchronized input is 0, an idle receiver leaves IDLE for START. It checks the start bit again on the 8th following tick. If the input is 1 at that sample, the receiver goes back to IDLE and no flag or data changes.
- R2: Data bits are taken least significant bit first, one every 16 ticks after the start-bit check. After `DATA_W` bits comes the parity bit (only when `par_en`=1) and then the stop bit. The states run IDLE → START → DATA → (PARITY) → STOP → IDLE.
- R3: A frame with no error that completes while `rdy`=0 is copied to `rx_data` and sets `rdy`=1.
- R4: With `par_en`=1 and `par_odd`=0, the data bits and the parity bit together must hold an even number of ones. With `par_odd`=1 they must hold an odd number. A mismatch sets `par_err`.
- R5: A stop bit sampled as 0 sets `frm_err`.
- R6: A frame with a framing error, a parity error or both that completes while `rdy`=0 is still copied to `rx_data`, but `rdy` stays 0.
- R7: A frame that completes while `rdy`=1 sets `ovr_err`. `rdy` stays 1 and `rx_data` keeps its value. The framing and parity errors of that frame are still flagged.
- R8: `rd_strobe` clears `rdy`. `clr_ovr`, `clr_frm` and `clr_par` each clear their own flag. If a clear and a set fall on the same cycle, the set wins.
- R9: A continuously low input (a break) is received as repeated all-zero frames. Each one sets `frm_err`, so a cleared `frm_err` is set again within one frame time.
- R10: While `rx_en`=0 the receiver stays in IDLE and ignores the input. Deasserting `rx_en` changes no flag and does not change `rx_data`.
- R11: After reset all flags are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling strobe, 16 pulses per bit |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Expect a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Data register read, clears `rdy` |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_frm | input | 1 | Clear framing error flag |
| clr_par | input | 1 | Clear parity error flag |
| rx_data | output | DATA_W | Received data register |
| rdy | output | 1 | Data ready flag |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |

## Verification
A line change reaches the framer two clocks later, through the synchronizer. The framer raises its completion pulse one clock after the tick that samples the stop bit, and the flags and data register update on the clock after that. The driver holds the line idle for 20 ticks after each stop bit before it pushes the expected state into the scoreboard, so every result has settled well before the monitor compares it on a falling clock edge. Clears and read strobes take effect on the rising edge inside their one-clock pulse and are checked on the next falling edge. The break checks sample at tick 160 and tick 320, which lie between frame completions that fall 153 ticks apart.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= 1'b1;
                else        pipe_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_os_rx_framer.sv
module uart_os_rx_framer
    import uart_os_rx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          en,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          par_bad,
    output logic          stop_bad
);
    localparam int CW   = $clog2(OSR);
    localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
    localparam int MID  = OSR / 2 - 1;
    localparam int LAST = OSR - 1;

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] shreg_q;
    logic          done_q, par_bad_q, stop_bad_q;
    logic          at_mid, at_full, last_bit;

    assign at_mid   = tick && (cnt_q == CW'(MID));
    assign at_full  = tick && (cnt_q == CW'(LAST));
    assign last_bit = (bit_q == BW'(DW - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rx) state_d = RX_START;
            RX_START:  if (at_mid)      state_d = rx ? RX_IDLE : RX_DATA;
            RX_DATA:   if (at_full && last_bit)
                           state_d = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (at_full)     state_d = RX_STOP;
            RX_STOP:   if (at_full)     state_d = RX_IDLE;
            default:                    state_d = RX_IDLE;
        endcase
        if (!en) state_d = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            done_q     <= 1'b0;
            par_bad_q  <= 1'b0;
            stop_bad_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
                bit_q <= '0;
            end else begin
                unique case (state_q)
                    RX_IDLE: begin
                        cnt_q <= '0;
                        bit_q <= '0;
                    end
                    RX_START: begin
                        if (tick) cnt_q <= at_mid ? '0 : cnt_q + 1'b1;
                        par_bad_q <= 1'b0;
                    end
                    RX_DATA: begin
                        if (tick) cnt_q <= at_full ? '0 : cnt_q + 1'b1;
                        if (at_full) begin
                            shreg_q <= {rx, shreg_q[DW-1:1]};
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (tick) cnt_q <= at_full ? '0 : cnt_q + 1'b1;
                        if (at_full) par_bad_q <= ((^shreg_q) ^ rx) != par_odd;
                    end
                    RX_STOP: begin
                        if (tick) cnt_q <= at_full ? '0 : cnt_q + 1'b1;
                        if (at_full) begin
                            stop_bad_q <= !rx;
                            done_q     <= 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign done     = done_q;
    assign data     = shreg_q;
    assign par_bad  = par_bad_q;
    assign stop_bad = stop_bad_q;
endmodule

// File: rtl/uart_os_rx_flags.sv
module uart_os_rx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] fdata,
    input  logic          fpar_bad,
    input  logic          fstop_bad,
    input  logic          rd_strobe,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    output logic [DW-1:0] rx_data,
    output logic          rdy,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          par_err
);
    logic [DW-1:0] data_q;
    logic          rdy_q, ovr_q, frm_q, par_q;
    logic          xfer, set_rdy, set_ovr, set_frm, set_par;

    assign xfer    = done && !rdy_q;
    assign set_rdy = xfer && !fpar_bad && !fstop_bad;
    assign set_ovr = done && rdy_q;
    assign set_frm = done && fstop_bad;
    assign set_par = done && fpar_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
            frm_q  <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            if (xfer) data_q <= fdata;
            rdy_q <= set_rdy | (rdy_q & ~rd_strobe);
            ovr_q <= set_ovr | (ovr_q & ~clr_ovr);
            frm_q <= set_frm | (frm_q & ~clr_frm);
            par_q <= set_par | (par_q & ~clr_par);
        end
    end

    assign rx_data = data_q;
    assign rdy     = rdy_q;
    assign ovr_err = ovr_q;
    assign frm_err = frm_q;
    assign par_err = par_q;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_strobe,
    input  logic              clr_ovr,
    input  logic              clr_frm,
    input  logic              clr_par,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdy,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err
);
    logic              rx_s;
    logic              frame_done;
    logic [DATA_W-1:0] f_data;
    logic              f_par_bad, f_stop_bad;

    uart_os_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    uart_os_rx_framer #(.DW(DATA_W), .OSR(OSR)) framer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .rx      (rx_s),
        .en      (rx_en),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done    (frame_done),
        .data    (f_data),
        .par_bad (f_par_bad),
        .stop_bad(f_stop_bad)
    );

    uart_os_rx_flags #(.DW(DATA_W)) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (frame_done),
        .fdata    (f_data),
        .fpar_bad (f_par_bad),
        .fstop_bad(f_stop_bad),
        .rd_strobe(rd_strobe),
        .clr_ovr  (clr_ovr),
        .clr_frm  (clr_frm),
        .clr_par  (clr_par),
        .rx_data  (rx_data),
        .rdy      (rdy),
        .ovr_err  (ovr_err),
        .frm_err  (frm_err),
        .par_err  (par_err)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          clr_ovr,
    input logic          clr_frm,
    input logic          frame_done,
    input logic          f_par_bad,
    input logic          f_stop_bad,
    input logic [DW-1:0] rx_data,
    input logic          rdy,
    input logic          ovr_err,
    input logic          frm_err
);
    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && rdy |=> ovr_err && rdy);

    a_r7_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && rdy |=> $stable(rx_data));

    a_r5_stop_low_flags: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && f_stop_bad |=> frm_err);

    a_r6_error_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !rdy && (f_stop_bad || f_par_bad) |=> !rdy);

    a_r8_frm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_frm && !frame_done |=> !frm_err);

    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err && !clr_ovr |=> ovr_err);

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en && $past(!rx_en) |-> !frame_done);
endmodule

bind uart_os_rx uart_os_rx_chk #(.DW(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .clr_ovr   (clr_ovr),
    .clr_frm   (clr_frm),
    .frame_done(frame_done),
    .f_par_bad (f_par_bad),
    .f_stop_bad(f_stop_bad),
    .rx_data   (rx_data),
    .rdy       (rdy),
    .ovr_err   (ovr_err),
    .frm_err   (frm_err)
);

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 4;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_en = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       clr_ovr = 1'b0;
    logic       clr_frm = 1'b0;
    logic       clr_par = 1'b0;
    logic [7:0] rx_data;
    logic       rdy, ovr_err, frm_err, par_err;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    typedef struct {
        logic [7:0] data;
        logic       rdy, ovr, frm, par;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    logic [7:0] m_data = 8'h00;
    logic       m_rdy = 0, m_ovr = 0, m_frm = 0, m_par = 0;

    uart_os_rx dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
        .rd_strobe(rd_strobe), .clr_ovr(clr_ovr), .clr_frm(clr_frm),
        .clr_par(clr_par), .rx_data(rx_data), .rdy(rdy),
        .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tcnt = 0;
    always @(posedge clk) begin
        tcnt    <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        os_tick <= (tcnt == TDIV - 1);
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic tick_wait(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!os_tick) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input bit use_par,
                              input bit odd, input bit flip_par,
                              input bit stop_val, input string req);
        logic pbit;
        exp_t e;
        par_en  = use_par;
        par_odd = odd;
        tick_wait(1);
        rx_in = 1'b0;
        tick_wait(16);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            tick_wait(16);
        end
        if (use_par) begin
            pbit  = (^d) ^ odd ^ flip_par;
            rx_in = pbit;
            tick_wait(16);
        end
        rx_in = stop_val;
        tick_wait(16);
        rx_in = 1'b1;
        tick_wait(20);
        if (rx_en) begin
            if (m_rdy) m_ovr = 1;
            else begin
                m_data = d;
                if (!(use_par && flip_par) && stop_val) m_rdy = 1;
            end
            if (!stop_val) m_frm = 1;
            if (use_par && flip_par) m_par = 1;
        end
        e.data = m_data; e.rdy = m_rdy; e.ovr = m_ovr;
        e.frm = m_frm; e.par = m_par; e.req = req;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            e = sb_q.pop_front();
            check(e.req, "rx_data", 32'(rx_data), 32'(e.data));
            check(e.req, "rdy",     32'(rdy),     32'(e.rdy));
            check(e.req, "ovr_err", 32'(ovr_err), 32'(e.ovr));
            check(e.req, "frm_err", 32'(frm_err), 32'(e.frm));
            check(e.req, "par_err", 32'(par_err), 32'(e.par));
        end
    end

    task automatic pulse_read();
        @(negedge clk) rd_strobe = 1;
        @(negedge clk) rd_strobe = 0;
        m_rdy = 0;
    endtask

    task automatic check_all(input string req);
        check(req, "rx_data", 32'(rx_data), 32'(m_data));
        check(req, "rdy",     32'(rdy),     32'(m_rdy));
        check(req, "ovr_err", 32'(ovr_err), 32'(m_ovr));
        check(req, "frm_err", 32'(frm_err), 32'(m_frm));
        check(req, "par_err", 32'(par_err), 32'(m_par));
    endtask

    // watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11");

        // R2 R3: clean frame
        send_frame(8'hA5, 0, 0, 0, 1, "R3");
        // R7: overrun keeps old data
        send_frame(8'h5A, 0, 0, 0, 1, "R7");
        // R7 with framing error, R5
        send_frame(8'h11, 0, 0, 0, 0, "R7");

        // R8: clears
        pulse_read();
        @(negedge clk) clr_ovr = 1; clr_frm = 1;
        @(negedge clk) clr_ovr = 0; clr_frm = 0;
        m_ovr = 0; m_frm = 0;
        check_all("R8");

        // R4: even parity good, odd parity good
        send_frame(8'h3C, 1, 0, 0, 1, "R4");
        pulse_read();
        send_frame(8'h81, 1, 1, 0, 1, "R4");
        pulse_read();
        // R4 R6: parity error transfers but no ready
        send_frame(8'h7E, 1, 0, 1, 1, "R6");
        @(negedge clk) clr_par = 1;
        @(negedge clk) clr_par = 0;
        m_par = 0;
        check("R8", "par_err", 32'(par_err), 32'(0));

        // R5 R6: framing error only
        send_frame(8'h42, 0, 0, 0, 0, "R5");
        @(negedge clk) clr_frm = 1;
        @(negedge clk) clr_frm = 0;
        m_frm = 0;

        // R1: glitch on start
        tick_wait(1);
        rx_in = 1'b0;
        tick_wait(4);
        rx_in = 1'b1;
        tick_wait(40);
        check_all("R1");
        send_frame(8'h99, 0, 0, 0, 1, "R1");

        // R10: disabled receiver ignores frame
        pulse_read();
        rx_en = 1'b0;
        send_frame(8'hF0, 0, 0, 0, 1, "R10");
        rx_en = 1'b1;

        // R9: break
        tick_wait(1);
        rx_in = 1'b0;
        tick_wait(160);
        check("R9", "frm_err first", 32'(frm_err), 32'(1));
        check("R9", "rx_data", 32'(rx_data), 32'(0));
        check("R9", "rdy", 32'(rdy), 32'(0));
        @(negedge clk) clr_frm = 1;
        @(negedge clk) clr_frm = 0;
        check("R9", "frm_err cleared", 32'(frm_err), 32'(0));
        tick_wait(160);
        check("R9", "frm_err again", 32'(frm_err), 32'(1));
        rx_in = 1'b1;
        @(negedge clk) rx_en = 1'b0;
        repeat (8) @(negedge clk);
        check("R10", "frm_err kept", 32'(frm_err), 32'(1));
        check("R10", "rx_data kept", 32'(rx_data), 32'(0));
        repeat (200) @(negedge clk);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        done_flag = 1;
        report();
    end
endmodule